// File: doc/BRIEF.md
# Steered Two-Read Register File

This block is a sixteen-entry, sixteen-bit register file with two combinational read ports and one synchronous write port. Port A and the write port always use the same register number. Port B has its own register number. Software-visible instructions can reach only the lower eight entries. The upper eight entries serve as scratch storage that only microcode can address.

Each of the two register numbers comes from a five-bit control field. Its lowest bit chooses where the number comes from. When that bit is clear, the upper four bits of the field name any of the sixteen entries directly. When that bit is set, the number is taken from one of two three-bit instruction operand fields (the destination field or the source field), zero-extended on the left. A single shared selector picks between those two operand fields. The field that asked for instruction mode controls the selector, and the port-A field wins when both ask. Entry zero has no storage: it reads as zero and drops writes.

The steering logic is a purely combinational selector. There is no sequencing in this block, so it holds no control state beyond the storage itself.

Top module: `steer_regfile`

## Requirements
- R1: Both read ports are combinational. A write updates the entry named by the port-A address on the rising clock edge when `wr_en` is 1. A read in the same cycle as that write returns the old contents.
- R2: Entry 0 always reads as zero on both ports. A write addressed to entry 0 changes no entry.
- R3: While `rst` is 1 at a rising edge, every entry is cleared to zero. A write presented in that same cycle is not performed.
- R4: When bit 0 of a field is 0, that port's register number is field bits [4:1], and any of entries 0–15 can be reached.
- R5: When bit 0 of a field is 1, that port's register number is the chosen three-bit operand field with a 0 prepended, so bit 3 of the number is 0 and entries 8–15 are out of reach.
- R6: The operand field is chosen by bit 1 of the controlling field: 0 picks `dst_fld` and 1 picks `src_fld`. The controlling field is `dsa_fld` when its bit 0 is 1. Otherwise it is `sb_fld`.
- R7: When both fields have bit 0 set, both ports receive the same register number, and bit 1 of `sb_fld` has no effect.
- R8: After a write to a non-zero entry, reading that entry on port B in the following cycle returns the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable for the port-A address |
| wr_data | input | 16 | Data to write |
| dsa_fld | input | 5 | Control field for port-A/write address |
| sb_fld | input | 5 | Control field for port-B address |
| dst_fld | input | 3 | Instruction destination operand field |
| src_fld | input | 3 | Instruction source operand field |
| a_addr | output | 4 | Resolved port-A/write register number |
| b_addr | output | 4 | Resolved port-B register number |
| a_data | output | 16 | Port-A read data |
| b_data | output | 16 | Port-B read data |

## Verification
The assertions assume that every input is a known value at each rising edge outside reset. They also assume that reset is held through the first edge, so that no check looks back at a cycle before the storage was cleared. The stimulus asserts reset from time zero. It then changes the inputs only on falling edges, taking every field value from a defined pattern or from the unsigned random function. All five-bit field codes, including the case where both fields request instruction mode with opposing selector bits, appear in the random phase.

// File: rtl/steer_regfile_pkg.sv
package steer_regfile_pkg;

    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_REG_N  = 16;

    // position of the source-select bit and the operand-select bit in a field
    localparam int unsigned MODE_BIT = 0;
    localparam int unsigned OPSEL_BIT = 1;

    typedef enum logic {
        SRC_MICRO = 1'b0,
        SRC_INSTR = 1'b1
    } addr_src_e;

    typedef enum logic {
        OP_DST = 1'b0,
        OP_SRC = 1'b1
    } op_pick_e;

endpackage

// File: rtl/rf_addr_steer.sv
module rf_addr_steer
    import steer_regfile_pkg::*;
#(
    parameter int unsigned AW = 4,
    localparam int unsigned FW = AW + 1,
    localparam int unsigned IW = AW - 1
) (
    input  logic [FW-1:0] dsa_fld,
    input  logic [FW-1:0] sb_fld,
    input  logic [IW-1:0] dst_fld,
    input  logic [IW-1:0] src_fld,
    output logic [AW-1:0] a_addr,
    output logic [AW-1:0] b_addr
);

    addr_src_e a_src;
    addr_src_e b_src;
    op_pick_e  pick;
    logic [IW-1:0] op_sel;
    logic [AW-1:0] instr_addr;

    always_comb begin
        a_src = addr_src_e'(dsa_fld[MODE_BIT]);
        b_src = addr_src_e'(sb_fld[MODE_BIT]);
        if (a_src == SRC_INSTR)
            pick = op_pick_e'(dsa_fld[OPSEL_BIT]);
        else
            pick = op_pick_e'(sb_fld[OPSEL_BIT]);
        unique case (pick)
            OP_DST:  op_sel = dst_fld;
            OP_SRC:  op_sel = src_fld;
            default: op_sel = dst_fld;
        endcase
        instr_addr = {{(AW-IW){1'b0}}, op_sel};
    end

    always_comb begin
        unique case (a_src)
            SRC_MICRO: a_addr = dsa_fld[FW-1:1];
            SRC_INSTR: a_addr = instr_addr;
            default:   a_addr = dsa_fld[FW-1:1];
        endcase
        unique case (b_src)
            SRC_MICRO: b_addr = sb_fld[FW-1:1];
            SRC_INSTR: b_addr = instr_addr;
            default:   b_addr = sb_fld[FW-1:1];
        endcase
    end

endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned REG_N  = 16,
    localparam int unsigned AW = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_a_addr,
    input  logic [AW-1:0]     rd_b_addr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data
);

    logic [DATA_W-1:0] cell_q [REG_N];

    // entry 0 is a hard zero with no storage behind it
    assign cell_q[0] = '0;

    for (genvar i = 1; i < REG_N; i++) begin : g_cell
        logic [DATA_W-1:0] q;
        logic              hit;
        assign hit = wr_en && (wr_addr == AW'(i));
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (hit)
                q <= wr_data;
        end
        assign cell_q[i] = q;
    end

    assign rd_a_data = cell_q[rd_a_addr];
    assign rd_b_data = cell_q[rd_b_addr];

endmodule

// File: rtl/steer_regfile.sv
module steer_regfile
    import steer_regfile_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned REG_N  = DEF_REG_N,
    localparam int unsigned AW = $clog2(REG_N),
    localparam int unsigned FW = AW + 1,
    localparam int unsigned IW = AW - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FW-1:0]     dsa_fld,
    input  logic [FW-1:0]     sb_fld,
    input  logic [IW-1:0]     dst_fld,
    input  logic [IW-1:0]     src_fld,
    output logic [AW-1:0]     a_addr,
    output logic [AW-1:0]     b_addr,
    output logic [DATA_W-1:0] a_data,
    output logic [DATA_W-1:0] b_data
);

    rf_addr_steer #(.AW(AW)) u_steer (
        .dsa_fld (dsa_fld),
        .sb_fld  (sb_fld),
        .dst_fld (dst_fld),
        .src_fld (src_fld),
        .a_addr  (a_addr),
        .b_addr  (b_addr)
    );

    rf_store #(.DATA_W(DATA_W), .REG_N(REG_N)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (a_addr),
        .wr_data   (wr_data),
        .rd_a_addr (a_addr),
        .rd_b_addr (b_addr),
        .rd_a_data (a_data),
        .rd_b_data (b_data)
    );

endmodule

// File: rtl/steer_regfile_chk.sv
module steer_regfile_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned AW = 4,
    localparam int unsigned FW = AW + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [FW-1:0]     dsa_fld,
    input logic [FW-1:0]     sb_fld,
    input logic [AW-1:0]     a_addr,
    input logic [AW-1:0]     b_addr,
    input logic [DATA_W-1:0] a_data,
    input logic [DATA_W-1:0] b_data
);

    // R2
    zero_entry_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (a_addr == '0) |-> (a_data == '0));

    // R2
    zero_entry_b_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (b_addr == '0) |-> (b_data == '0));

    // R3
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (a_data == '0 && b_data == '0));

    // R5
    instr_low_bank_chk: assert property (@(posedge clk) disable iff (rst)
        dsa_fld[0] |-> (a_addr[AW-1] == 1'b0));

    // R7
    shared_instr_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (dsa_fld[0] && sb_fld[0]) |-> (a_addr == b_addr));

    // R8
    write_then_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(a_addr) != '0 && b_addr == $past(a_addr))
            |-> (b_data == $past(wr_data)));

endmodule

bind steer_regfile steer_regfile_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .dsa_fld (dsa_fld),
    .sb_fld  (sb_fld),
    .a_addr  (a_addr),
    .b_addr  (b_addr),
    .a_data  (a_data),
    .b_data  (b_data)
);

// File: tb/steer_regfile_tb.sv
`timescale 1ns/1ps
module steer_regfile_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [4:0]  dsa_fld;
    logic [4:0]  sb_fld;
    logic [2:0]  dst_fld;
    logic [2:0]  src_fld;
    logic [3:0]  a_addr;
    logic [3:0]  b_addr;
    logic [15:0] a_data;
    logic [15:0] b_data;

    int checks = 0;
    int errors = 0;
    int model [16];
    bit done = 0;

    always #2 clk = ~clk;

    steer_regfile u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .dsa_fld(dsa_fld), .sb_fld(sb_fld), .dst_fld(dst_fld), .src_fld(src_fld),
        .a_addr(a_addr), .b_addr(b_addr), .a_data(a_data), .b_data(b_data)
    );

    function automatic int ref_addr(input logic [4:0] own, input logic [4:0] dsa,
                                    input logic [4:0] sb, input logic [2:0] d,
                                    input logic [2:0] s);
        int use_src;
        if (own[0] == 1'b0) return int'(own[4:1]);
        if (dsa[0]) use_src = dsa[1]; else use_src = sb[1];
        return use_src ? int'(s) : int'(d);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // drive after falling edge, check mid-low phase, then update model at rising edge
    task automatic cyc(input string tag, input logic r, input logic we, input logic [15:0] wd,
                       input logic [4:0] dsa, input logic [4:0] sb,
                       input logic [2:0] d, input logic [2:0] s);
        int ea, eb;
        rst = r; wr_en = we; wr_data = wd; dsa_fld = dsa; sb_fld = sb; dst_fld = d; src_fld = s;
        #1;
        ea = ref_addr(dsa, dsa, sb, d, s);
        eb = ref_addr(sb, dsa, sb, d, s);
        if (!r) begin
            check(tag, "a_addr", int'(a_addr), ea);
            check(tag, "b_addr", int'(b_addr), eb);
            check(tag, "a_data", int'(a_data), model[ea]);
            check(tag, "b_data", int'(b_data), model[eb]);
        end
        @(posedge clk);
        if (r) begin
            for (int k = 0; k < 16; k++) model[k] = 0;
        end else if (we && ea != 0) begin
            model[ea] = int'(wd);
        end
        @(negedge clk);
    endtask

    function automatic logic [4:0] mf(input int n);
        return {4'(n), 1'b0};
    endfunction

    initial begin
        for (int k = 0; k < 16; k++) model[k] = 0;
        rst = 1; wr_en = 0; wr_data = 0; dsa_fld = 0; sb_fld = 0; dst_fld = 0; src_fld = 0;
        @(negedge clk);
        cyc("R3", 1, 1, 16'hFFFF, mf(5), mf(5), 0, 0);
        cyc("R3", 1, 0, 0, 0, 0, 0, 0);
        // R3 reset state: every entry zero, and the write held during reset was dropped
        for (int k = 0; k < 16; k++) cyc("R3", 0, 0, 0, mf(k), mf(15 - k), 0, 0);
        // R4 fill all entries through microcode addresses, R1 old value seen during write
        for (int k = 1; k < 16; k++) cyc("R1", 0, 1, 16'(16'h1000 + k * 16'h0111), mf(k), mf(k), 0, 0);
        for (int k = 0; k < 16; k++) cyc("R4", 0, 0, 0, mf(k), mf((k + 8) % 16), 0, 0);
        // R2 write to entry 0 is dropped
        cyc("R2", 0, 1, 16'hDEAD, mf(0), mf(0), 0, 0);
        cyc("R2", 0, 0, 0, mf(0), mf(0), 0, 0);
        // R5/R6 port A in instruction mode, picking DST then SRC
        cyc("R6", 0, 0, 0, 5'b00001, mf(12), 3'd5, 3'd2);
        cyc("R6", 0, 0, 0, 5'b00011, mf(12), 3'd5, 3'd2);
        // R6 port B in instruction mode controls the pick when A is micro
        cyc("R6", 0, 0, 0, mf(9), 5'b00001, 3'd7, 3'd3);
        cyc("R6", 0, 0, 0, mf(9), 5'b00011, 3'd7, 3'd3);
        // R7 both instruction mode with conflicting select bits: DSA wins
        cyc("R7", 0, 0, 0, 5'b00001, 5'b00011, 3'd4, 3'd6);
        cyc("R7", 0, 0, 0, 5'b00011, 5'b00001, 3'd4, 3'd6);
        // R5 write through instruction field lands in lower bank only
        cyc("R5", 0, 1, 16'hA5A5, 5'b11111, mf(15), 3'd6, 3'd7);
        cyc("R5", 0, 0, 0, mf(7), mf(15), 0, 0);
        // R8 write then immediate read on B
        cyc("R8", 0, 1, 16'h5A5A, mf(11), mf(11), 0, 0);
        cyc("R8", 0, 0, 0, mf(3), mf(11), 0, 0);
        // random phase covering all field codes
        for (int n = 0; n < 600; n++)
            cyc("R1", 0, 1'($urandom), 16'($urandom), 5'($urandom), 5'($urandom),
                3'($urandom), 3'($urandom));
        // R3 reset mid-run then confirm zero contents
        cyc("R3", 1, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 16; k++) cyc("R3", 0, 0, 0, mf(k), mf(k), 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule